// File: doc/BRIEF.md
# Software Write-Protection Command Sequencer

This block watches the byte writes that a host issues to a paged nonvolatile memory. It looks for two fixed command sequences written as address/data pairs. The first is a three-write enable sequence. The second is a six-write disable sequence. The block keeps a protection flag and, for every write, decides whether the byte may go to the page latch, is used up as part of a command, or is refused.

Writes are grouped into load windows. A write extends the current window when it arrives within `WINDOW` cycles of the previous one. When a window closes, the programming timer runs for `PROG_CYCLES` cycles if the window held anything to program. While protection is on, the enable sequence works as a one-shot unlock for the data writes that follow it in the same window. A protected write that has no prefix stores nothing, but it still starts the programming timer.

The protection flag does not respond to the ordinary reset. It follows only its own nonvolatile-init input, which loads the delivered default (off).

Top module: `wprot_sequencer`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy_o` and `load_open_o` are 0. Pulsing `nv_init_i` sets `prot_o` to 0.
- R2: While protection is off, a write that is not part of a command sequence raises `wr_store_o` in the same cycle, and `cmd_byte_o` stays 0.
- R3: Each write of the enable sequence raises `cmd_byte_o` and keeps `wr_store_o` at 0. The enable sequence is, in order: addr 0x05555 data 0xAA, then addr 0x02AAA data 0x55, then addr 0x05555 data 0xA0.
- R4: After a complete enable sequence, `prot_o` becomes 1 at the clock edge that closes the load window.
- R5: While protected, a write with no prefix has `wr_store_o` = 0 and `cmd_byte_o` = 0. It still makes `busy_o` go high when its window closes.
- R6: While protected, writes that follow a complete enable sequence in the same load window are stored, and there may be several of them.
- R7: The unlock lasts for one window only. In the next window, a write without the prefix is refused again.
- R8: The six-write disable sequence clears `prot_o` when its window closes, and none of its bytes is stored. The sequence is, in order: 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x80, 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x20.
- R9: A write that matches neither the next expected step nor a first step returns both matchers to idle and is treated as an ordinary write. A later third step therefore completes nothing.
- R10: A window closes `WINDOW` cycles after its last write. `busy_o` then stays high for exactly `PROG_CYCLES` cycles. Writes presented while busy are ignored: no store, no command, and no effect on the matchers.
- R11: Asserting `rst_n` does not change `prot_o`.
- R12: A window that holds only a partial command sequence does not start the programming timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of sequencing state (not the protection flag) |
| nv_init_i | input | 1 | Loads the protection flag with its delivered default |
| wr_valid_i | input | 1 | A byte write is presented this cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| wr_store_o | output | 1 | This write may go to the page latch |
| cmd_byte_o | output | 1 | This write was consumed as a command byte |
| busy_o | output | 1 | Programming timer running |
| load_open_o | output | 1 | A load window is open |
| prot_o | output | 1 | Protection flag |

## Verification
The assertions check on every cycle that:
- writes are silent while the timer runs;
- a command byte is never stored;
- a store under protection happens only when an unlock is live;
- the protection flag changes only together with the start of a programming period.

Only the bench scenarios can show the following:
- the sequence content and the one-shot scope of the unlock;
- recovery of the matchers after a broken sequence;
- the exact window and timer lengths;
- the flag surviving a reset.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // control state of the sequencer top, cleared by rst_n
    typedef struct packed {
        logic unlock;    // enable prefix seen in the open window
        logic pend_en;   // protection to be set at window close
        logic pend_dis;  // protection to be cleared at window close
        logic work;      // window holds something to program
    } ctl_t;

endpackage

// File: rtl/wprot_matcher.sv
module wprot_matcher #(
    parameter int ADDR_W = 17,
    parameter int LEN    = 3,
    parameter logic [LEN-1:0][ADDR_W-1:0] SEQ_ADDR = '0,
    parameter logic [LEN-1:0][7:0]        SEQ_DATA = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic              hit_o,
    output logic              done_o
);

    localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
    } mst_t;

    mst_t st_d, st_q;
    logic match_next, match_first;

    always_comb begin
        st_d        = st_q;
        match_next  = (addr_i == SEQ_ADDR[st_q.cnt]) && (data_i == SEQ_DATA[st_q.cnt]);
        match_first = (addr_i == SEQ_ADDR[0]) && (data_i == SEQ_DATA[0]);
        hit_o       = step_i && (match_next || match_first);
        done_o      = step_i && match_next && (st_q.cnt == IDX_W'(LEN - 1));
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            if (match_next) begin
                st_d.cnt = done_o ? '0 : st_q.cnt + IDX_W'(1);
            end else if (match_first) begin
                st_d.cnt = IDX_W'(1);
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wprot_window.sv
module wprot_window #(
    parameter int WINDOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    output logic open_o,
    output logic close_o
);

    localparam int GAP_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    typedef struct packed {
        logic             open;
        logic [GAP_W-1:0] gap;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        close_o = st_q.open && !wr_i && (st_q.gap == GAP_W'(WINDOW - 1));
        if (wr_i) begin
            st_d.open = 1'b1;
            st_d.gap  = '0;
        end else if (close_o) begin
            st_d.open = 1'b0;
            st_d.gap  = '0;
        end else if (st_q.open) begin
            st_d.gap  = st_q.gap + GAP_W'(1);
        end
    end

    assign open_o = st_q.open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wprot_busy.sv
module wprot_busy #(
    parameter int PROG_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } bst_t;

    bst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(PROG_CYCLES - 1);
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    assign busy_o = st_q.busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wprot_sequencer.sv
module wprot_sequencer
    import wprot_pkg::*;
#(
    parameter int   ADDR_W      = 17,
    parameter int   WINDOW      = 8,
    parameter int   PROG_CYCLES = 20,
    parameter logic NV_DEFAULT  = 1'b0,
    // index 0 is the first write of each sequence
    parameter logic [2:0][ADDR_W-1:0] EN_ADDR  = {17'h05555, 17'h02AAA, 17'h05555},
    parameter logic [2:0][7:0]        EN_DATA  = {8'hA0, 8'h55, 8'hAA},
    parameter logic [5:0][ADDR_W-1:0] DIS_ADDR = {17'h05555, 17'h02AAA, 17'h05555,
                                                  17'h05555, 17'h02AAA, 17'h05555},
    parameter logic [5:0][7:0]        DIS_DATA = {8'h20, 8'h55, 8'hAA, 8'h80, 8'h55, 8'hAA}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_init_i,
    input  logic              wr_valid_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic              wr_store_o,
    output logic              cmd_byte_o,
    output logic              busy_o,
    output logic              load_open_o,
    output logic              prot_o
);

    localparam int EN_LEN  = 3;
    localparam int DIS_LEN = 6;

    ctl_t ctl_d, ctl_q;
    logic prot_d, prot_q;
    logic accept, step, close, start;
    logic en_hit, en_done, dis_hit, dis_done;
    logic rejected;

    assign accept = wr_valid_i && !busy_o;
    assign step   = accept && !ctl_q.unlock;

    wprot_matcher #(
        .ADDR_W  (ADDR_W),
        .LEN     (EN_LEN),
        .SEQ_ADDR(EN_ADDR),
        .SEQ_DATA(EN_DATA)
    ) en_match_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(close),
        .step_i (step),
        .addr_i (wr_addr_i),
        .data_i (wr_data_i),
        .hit_o  (en_hit),
        .done_o (en_done)
    );

    wprot_matcher #(
        .ADDR_W  (ADDR_W),
        .LEN     (DIS_LEN),
        .SEQ_ADDR(DIS_ADDR),
        .SEQ_DATA(DIS_DATA)
    ) dis_match_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(close),
        .step_i (step),
        .addr_i (wr_addr_i),
        .data_i (wr_data_i),
        .hit_o  (dis_hit),
        .done_o (dis_done)
    );

    wprot_window #(
        .WINDOW(WINDOW)
    ) window_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (accept),
        .open_o (load_open_o),
        .close_o(close)
    );

    wprot_busy #(
        .PROG_CYCLES(PROG_CYCLES)
    ) busy_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .busy_o (busy_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        prot_d     = prot_q;
        cmd_byte_o = step && (en_hit || dis_hit);
        wr_store_o = accept && !cmd_byte_o && (ctl_q.unlock || !prot_q);
        rejected   = accept && !cmd_byte_o && !wr_store_o;
        start      = close && ctl_q.work;

        if (close) begin
            if (ctl_q.pend_en) begin
                prot_d = 1'b1;
            end else if (ctl_q.pend_dis) begin
                prot_d = 1'b0;
            end
            ctl_d = '0;
        end else begin
            if (en_done) begin
                ctl_d.unlock   = 1'b1;
                ctl_d.pend_en  = 1'b1;
                ctl_d.pend_dis = 1'b0;
            end else if (dis_done) begin
                ctl_d.pend_dis = 1'b1;
                ctl_d.pend_en  = 1'b0;
            end
            if (wr_store_o || rejected || en_done || dis_done) begin
                ctl_d.work = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // protection flag: only the nonvolatile init loads it, reset leaves it
    always_ff @(posedge clk) begin
        if (nv_init_i) begin
            prot_q <= NV_DEFAULT;
        end else if (rst_n) begin
            prot_q <= prot_d;
        end
    end

    assign prot_o = prot_q;

endmodule

// File: rtl/wprot_checker.sv
module wprot_checker (
    input logic clk,
    input logic rst_n,
    input logic nv_init_i,
    input logic wr_store_o,
    input logic cmd_byte_o,
    input logic busy_o,
    input logic load_open_o,
    input logic prot_o,
    input logic unlock_i
);

    // R10: nothing is stored or consumed while the timer runs
    a_r10_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!wr_store_o && !cmd_byte_o));

    // R10: the window is closed while programming
    a_r10_no_window_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_open_o);

    // R10: an accepted write leaves the window open
    a_r10_open_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_store_o || cmd_byte_o) |=> load_open_o);

    // R3: a command byte never reaches the latch
    a_r3_cmd_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_byte_o |-> !wr_store_o);

    // R6: under protection a store needs a live unlock
    a_r6_store_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_o && wr_store_o) |-> unlock_i);

    // R4 / R8: the flag moves only when a programming period starts
    a_r4_prot_with_busy: assert property (@(posedge clk) disable iff (!rst_n || nv_init_i)
        (!$stable(prot_o) && !$past(nv_init_i)) |-> $rose(busy_o));

endmodule

bind wprot_sequencer wprot_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .nv_init_i  (nv_init_i),
    .wr_store_o (wr_store_o),
    .cmd_byte_o (cmd_byte_o),
    .busy_o     (busy_o),
    .load_open_o(load_open_o),
    .prot_o     (prot_o),
    .unlock_i   (ctl_q.unlock)
);

// File: tb/wprot_sequencer_tb.sv
module wprot_sequencer_tb_top;

    localparam int WINDOW = 8;
    localparam int PROG   = 20;

    typedef struct packed {
        logic        kind;  // 0 write, 1 wait for window close and timer
        logic [16:0] addr;
        logic [7:0]  data;
        logic        st;
        logic        cm;
        logic        pr;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t vw(logic [16:0] a, logic [7:0] d, logic s, logic c, logic [3:0] r);
        vw = '{kind: 1'b0, addr: a, data: d, st: s, cm: c, pr: 1'b0, req: r};
    endfunction

    function automatic vec_t vg(logic p, logic [3:0] r);
        vg = '{kind: 1'b1, addr: '0, data: '0, st: 1'b0, cm: 1'b0, pr: p, req: r};
    endfunction

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        vw(17'h00100, 8'h11, 1, 0, 2),  // R2 plain write while unprotected
        vg(0, 2),
        vw(17'h05555, 8'hAA, 0, 1, 3),  // R3 enable sequence
        vw(17'h02AAA, 8'h55, 0, 1, 3),
        vw(17'h05555, 8'hA0, 0, 1, 3),
        vw(17'h00200, 8'h33, 1, 0, 6),  // R6 data after prefix
        vg(1, 4),                       // R4 flag set at close
        vw(17'h00300, 8'h44, 0, 0, 5),  // R5 refused
        vg(1, 5),
        vw(17'h05555, 8'hAA, 0, 1, 6),  // R6 prefix again
        vw(17'h02AAA, 8'h55, 0, 1, 6),
        vw(17'h05555, 8'hA0, 0, 1, 6),
        vw(17'h00301, 8'h55, 1, 0, 6),
        vw(17'h00302, 8'h56, 1, 0, 6),
        vg(1, 6),
        vw(17'h00303, 8'h66, 0, 0, 7),  // R7 unlock was one-shot
        vg(1, 7),
        vw(17'h05555, 8'hAA, 0, 1, 9),  // R9 broken while protected
        vw(17'h00400, 8'h77, 0, 0, 9),
        vw(17'h05555, 8'hA0, 0, 0, 9),
        vg(1, 9),
        vw(17'h05555, 8'hAA, 0, 1, 8),  // R8 disable sequence
        vw(17'h02AAA, 8'h55, 0, 1, 8),
        vw(17'h05555, 8'h80, 0, 1, 8),
        vw(17'h05555, 8'hAA, 0, 1, 8),
        vw(17'h02AAA, 8'h55, 0, 1, 8),
        vw(17'h05555, 8'h20, 0, 1, 8),
        vg(0, 8),
        vw(17'h05555, 8'hAA, 0, 1, 9),  // R9 broken while unprotected
        vw(17'h00500, 8'h12, 1, 0, 9),
        vw(17'h05555, 8'hA0, 1, 0, 9),
        vg(0, 9)
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nv_init_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [16:0] wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic        wr_store_o, cmd_byte_o, busy_o, load_open_o, prot_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wprot_sequencer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .nv_init_i  (nv_init_i),
        .wr_valid_i (wr_valid_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .wr_store_o (wr_store_o),
        .cmd_byte_o (cmd_byte_o),
        .busy_o     (busy_o),
        .load_open_o(load_open_o),
        .prot_o     (prot_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic do_wr(input logic [16:0] a, input logic [7:0] d, output logic s, output logic c);
        @(negedge clk);
        wr_valid_i = 1'b1;
        wr_addr_i  = a;
        wr_data_i  = d;
        #1;
        s = wr_store_o;
        c = cmd_byte_o;
        @(posedge clk);
        #1 wr_valid_i = 1'b0;
    endtask

    task automatic settle();
        repeat (WINDOW + PROG + 3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic s, c;
        int   waits, blen;
        // R1 reset and nonvolatile init
        nv_init_i = 1'b1;
        repeat (2) @(posedge clk);
        #1 nv_init_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(busy_o == 0 && load_open_o == 0, "R1 in reset", {busy_o, load_open_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prot_o == 0, "R1 default flag", prot_o, 0);
        chk(busy_o == 0 && load_open_o == 0, "R1 after reset", {busy_o, load_open_o}, 0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].kind == 1'b0) begin
                do_wr(VECS[i].addr, VECS[i].data, s, c);
                chk({s, c} == {VECS[i].st, VECS[i].cm}, $sformatf("R%0d write %0d", VECS[i].req, i),
                    {s, c}, {VECS[i].st, VECS[i].cm});
            end else begin
                settle();
                chk(prot_o == VECS[i].pr, $sformatf("R%0d flag at %0d", VECS[i].req, i),
                    prot_o, VECS[i].pr);
            end
        end

        // R10 window length and timer length
        do_wr(17'h00600, 8'h01, s, c);
        waits = 0;
        for (int k = 0; k < 4 * WINDOW && !busy_o; k++) begin
            @(negedge clk);
            if (!busy_o) waits++;
        end
        chk(waits == WINDOW, "R10 window length", waits, WINDOW);
        blen = 0;
        for (int k = 0; k < 4 * PROG && busy_o; k++) begin
            blen++;
            @(negedge clk);
        end
        chk(blen == PROG, "R10 busy length", blen, PROG);
        settle();

        // R10 write during busy ignored, matcher untouched
        do_wr(17'h00601, 8'h02, s, c);
        repeat (WINDOW + 2) @(negedge clk);
        do_wr(17'h05555, 8'hAA, s, c);
        chk({s, c} == 2'b00, "R10 write while busy", {s, c}, 0);
        settle();
        do_wr(17'h02AAA, 8'h55, s, c);
        chk({s, c} == 2'b10, "R10 matcher idle after busy", {s, c}, 2);
        settle();

        // R12 partial command does not start the timer
        do_wr(17'h05555, 8'hAA, s, c);
        repeat (WINDOW + 3) @(negedge clk);
        chk(busy_o == 0 && load_open_o == 0, "R12 no timer", {busy_o, load_open_o}, 0);
        settle();

        // enable, then R5 refused write still runs the timer
        do_wr(17'h05555, 8'hAA, s, c);
        do_wr(17'h02AAA, 8'h55, s, c);
        do_wr(17'h05555, 8'hA0, s, c);
        settle();
        chk(prot_o == 1, "R4 flag set", prot_o, 1);
        do_wr(17'h00700, 8'h09, s, c);
        chk({s, c} == 2'b00, "R5 refused", {s, c}, 0);
        repeat (WINDOW + 2) @(negedge clk);
        chk(busy_o == 1, "R5 busy after refusal", busy_o, 1);
        settle();

        // R11 reset keeps the flag, init clears it
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prot_o == 1, "R11 flag survives reset", prot_o, 1);
        nv_init_i = 1'b1;
        @(negedge clk);
        nv_init_i = 1'b0;
        @(negedge clk);
        chk(prot_o == 0, "R11 init clears flag", prot_o, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule